// File: doc/BRIEF.md
# Mixed-Width Dual-Clock Block RAM

This block is a synchronous RAM with two independent ports, A and B. Each port has its own clock and its own data width, and both ports reach the same storage. In any cycle, either port can read, write, or do both. Two writes, two reads, or one of each across the ports are all legal. Widths come from the non-parity family 1, 2, 4, 8 and 16 bits, which hold 8192 bits in total. Any two widths from that family may be paired. The parity family is 9 and 18 bits, which hold 9216 bits in total, and its widths pair only with each other.

Addressing is little-endian by position. A word of width W at address n covers bits `[n*W +: W]` of one linear bit space. A wide word therefore holds consecutive narrow words, with the lowest narrow address in its least significant bits. Each port has:
- a clock enable
- an address stall, which keeps the last latched address
- separate write and read enables
- byte-lane enables on the 16/18-bit widths
- an asynchronous clear of its output and address registers

A parameter picks what a port returns when it reads the word it is writing in the same cycle: the merged new word or the stored old word.

Top module: `mwram_tdp`

## Requirements
- R1: A port that writes a word and later reads the same address, with no write in between, returns that word on `q`. The word appears right after the clock edge at which the read was sampled.
- R2: Ports of different widths share one bit space. Word n of width W occupies bits `[n*W +: W]`. For example, 16-bit word 10 holds 4-bit words 40 to 43, with word 40 in bits [3:0].
- R3: At an edge where the port is enabled and the read enable is 0, `q` keeps its previous value, whether or not a write happens.
- R4: At an edge where the port's clock enable is 0, nothing changes: not `q`, not the latched address, not the stored contents.
- R5: At an enabled edge with stall 0, the port latches the address input. With stall 1, it ignores the address input, and the read and the write both use the latched address.
- R6: On a 16-bit (or 18-bit) port, byte-enable bit k covers lane bits `[k*L +: L]`, where L is 8 (or 9 in the parity family). A 0 leaves that lane unchanged on a write. On narrower ports, the byte-enable input has no effect.
- R7: When a port reads the address it writes in the same enabled cycle, `q` returns the merged new word if `RDW_NEW` is 1, or the pre-write word if `RDW_NEW` is 0.
- R8: When the clear input is 1, `q` and the latched address go to zero at once, without waiting for a clock edge, and they stay at zero while the clear is held.
- R9: Both ports can read and write disjoint addresses in the same period on their unrelated clocks, and each port returns its own data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| ce_a | input | 1 | Port A clock enable |
| aclr_a | input | 1 | Port A asynchronous clear of output and address registers |
| addr_a | input | ABITS_A | Port A word address |
| stall_a | input | 1 | Port A address stall |
| we_a | input | 1 | Port A write enable |
| re_a | input | 1 | Port A read enable |
| be_a | input | BEN_A | Port A byte-lane enables |
| din_a | input | WIDTH_A | Port A write data |
| q_a | output | WIDTH_A | Port A registered read data |
| clk_b | input | 1 | Port B clock |
| ce_b | input | 1 | Port B clock enable |
| aclr_b | input | 1 | Port B asynchronous clear of output and address registers |
| addr_b | input | ABITS_B | Port B word address |
| stall_b | input | 1 | Port B address stall |
| we_b | input | 1 | Port B write enable |
| re_b | input | 1 | Port B read enable |
| be_b | input | BEN_B | Port B byte-lane enables |
| din_b | input | WIDTH_B | Port B write data |
| q_b | output | WIDTH_B | Port B registered read data |

## Verification
On one port, a write and a read of the same address can fall in the same edge. The bench provokes this with full and partial byte enables. It drives identical stimulus into two instances, one built for new-data and one built for old-data results. The scoreboard expects the merged word from the first instance and the pre-write word from the second. Stall and write also fall together: a stalled write is judged by reading back the held address.

// File: rtl/mwram_pkg.sv
package mwram_pkg;

  function automatic bit is_parity_width(int w);
    return (w == 9) || (w == 18);
  endfunction

  function automatic int lane_bits(bit parity);
    return parity ? 9 : 8;
  endfunction

  function automatic int total_bits(bit parity);
    return parity ? 9216 : 8192;
  endfunction

  // number of byte-enable inputs a port of width w carries
  function automatic int lane_count(int w, int lane);
    return (w >= 2 * lane) ? (w / lane) : 1;
  endfunction

  function automatic int min_int(int x, int y);
    return (x < y) ? x : y;
  endfunction

endpackage

// File: rtl/mwram_bank.sv
// One storage bank, written only from its owner's clock. The stored value of a
// location is the XOR of both banks, so each bank has a single writer.
module mwram_bank #(
  parameter int ATOM   = 4,
  parameter int NATOM  = 2048,
  parameter int RW     = 4,
  parameter int RO     = 1,
  parameter int AW_W   = 9,
  parameter int AW_O   = 11,
  localparam int IW    = $clog2(NATOM)
) (
  input  logic                 clk,
  input  logic                 wr_en,
  input  logic [AW_W-1:0]      own_addr,
  input  logic [RW*ATOM-1:0]   wr_flip,
  output logic [RW*ATOM-1:0]   own_rd,
  input  logic [AW_O-1:0]      oth_addr,
  output logic [RO*ATOM-1:0]   oth_rd
);

  logic [ATOM-1:0] cells [NATOM] = '{default: '0};

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int j = 0; j < RW; j++) begin
        cells[IW'(int'(own_addr) * RW + j)] <=
          cells[IW'(int'(own_addr) * RW + j)] ^ wr_flip[j*ATOM +: ATOM];
      end
    end
  end

  for (genvar j = 0; j < RW; j++) begin : g_own
    assign own_rd[j*ATOM +: ATOM] = cells[IW'(int'(own_addr) * RW + j)];
  end

  for (genvar j = 0; j < RO; j++) begin : g_oth
    assign oth_rd[j*ATOM +: ATOM] = cells[IW'(int'(oth_addr) * RO + j)];
  end

endmodule

// File: rtl/mwram_port.sv
// Port control: clock enable, address stall, lane masking, read-during-write.
module mwram_port #(
  parameter int W       = 16,
  parameter int AB      = 9,
  parameter int LANE    = 8,
  parameter int BEN     = 2,
  parameter bit RDW_NEW = 1'b1
) (
  input  logic           clk,
  input  logic           ce,
  input  logic           aclr,
  input  logic [AB-1:0]  addr,
  input  logic           stall,
  input  logic           we,
  input  logic           re,
  input  logic [BEN-1:0] be,
  input  logic [W-1:0]   din,
  input  logic [W-1:0]   rd_own,
  input  logic [W-1:0]   rd_other,
  output logic [AB-1:0]  eff_addr,
  output logic           wr_en,
  output logic [W-1:0]   wr_flip,
  output logic [AB-1:0]  held,
  output logic [W-1:0]   q
);

  logic [W-1:0] cur_word;
  logic [W-1:0] lane_mask;
  logic [W-1:0] post_word;

  assign eff_addr = stall ? held : addr;
  assign cur_word = rd_own ^ rd_other;

  if (W >= 2 * LANE) begin : g_lanes
    for (genvar k = 0; k < BEN; k++) begin : g_lane
      assign lane_mask[k*LANE +: LANE] = {LANE{be[k]}};
    end
    if (BEN * LANE < W) begin : g_tail
      assign lane_mask[W-1:BEN*LANE] = '1;
    end
  end else begin : g_full
    logic unused_be;
    assign unused_be = ^be;
    assign lane_mask = '1;
  end

  assign wr_en     = ce & we;
  assign wr_flip   = wr_en ? ((din ^ cur_word) & lane_mask) : '0;
  assign post_word = cur_word ^ wr_flip;

  always_ff @(posedge clk or posedge aclr) begin
    if (aclr) begin
      held <= '0;
      q    <= '0;
    end else if (ce) begin
      held <= eff_addr;
      if (re) begin
        q <= RDW_NEW ? post_word : cur_word;
      end
    end
  end

endmodule

// File: rtl/mwram_tdp.sv
module mwram_tdp
  import mwram_pkg::*;
#(
  parameter int WIDTH_A = 16,
  parameter int WIDTH_B = 4,
  parameter bit RDW_NEW = 1'b1,
  localparam bit PARITY  = is_parity_width(WIDTH_A),
  localparam int LANE    = lane_bits(PARITY),
  localparam int TOTAL   = total_bits(PARITY),
  localparam int ATOM    = min_int(WIDTH_A, WIDTH_B),
  localparam int NATOM   = TOTAL / ATOM,
  localparam int RA      = WIDTH_A / ATOM,
  localparam int RB      = WIDTH_B / ATOM,
  localparam int ABITS_A = $clog2(TOTAL / WIDTH_A),
  localparam int ABITS_B = $clog2(TOTAL / WIDTH_B),
  localparam int BEN_A   = lane_count(WIDTH_A, LANE),
  localparam int BEN_B   = lane_count(WIDTH_B, LANE)
) (
  input  logic               clk_a,
  input  logic               ce_a,
  input  logic               aclr_a,
  input  logic [ABITS_A-1:0] addr_a,
  input  logic               stall_a,
  input  logic               we_a,
  input  logic               re_a,
  input  logic [BEN_A-1:0]   be_a,
  input  logic [WIDTH_A-1:0] din_a,
  output logic [WIDTH_A-1:0] q_a,
  input  logic               clk_b,
  input  logic               ce_b,
  input  logic               aclr_b,
  input  logic [ABITS_B-1:0] addr_b,
  input  logic               stall_b,
  input  logic               we_b,
  input  logic               re_b,
  input  logic [BEN_B-1:0]   be_b,
  input  logic [WIDTH_B-1:0] din_b,
  output logic [WIDTH_B-1:0] q_b
);

  logic [ABITS_A-1:0] eff_a, held_a;
  logic [ABITS_B-1:0] eff_b, held_b;
  logic               wen_a, wen_b;
  logic [WIDTH_A-1:0] flip_a, a_own, a_sees_b;
  logic [WIDTH_B-1:0] flip_b, b_own, b_sees_a;

  mwram_bank #(
    .ATOM(ATOM), .NATOM(NATOM), .RW(RA), .RO(RB), .AW_W(ABITS_A), .AW_O(ABITS_B)
  ) u_bank_a (
    .clk(clk_a), .wr_en(wen_a), .own_addr(eff_a), .wr_flip(flip_a),
    .own_rd(a_own), .oth_addr(eff_b), .oth_rd(b_sees_a)
  );

  mwram_bank #(
    .ATOM(ATOM), .NATOM(NATOM), .RW(RB), .RO(RA), .AW_W(ABITS_B), .AW_O(ABITS_A)
  ) u_bank_b (
    .clk(clk_b), .wr_en(wen_b), .own_addr(eff_b), .wr_flip(flip_b),
    .own_rd(b_own), .oth_addr(eff_a), .oth_rd(a_sees_b)
  );

  mwram_port #(
    .W(WIDTH_A), .AB(ABITS_A), .LANE(LANE), .BEN(BEN_A), .RDW_NEW(RDW_NEW)
  ) u_port_a (
    .clk(clk_a), .ce(ce_a), .aclr(aclr_a), .addr(addr_a), .stall(stall_a),
    .we(we_a), .re(re_a), .be(be_a), .din(din_a),
    .rd_own(a_own), .rd_other(a_sees_b),
    .eff_addr(eff_a), .wr_en(wen_a), .wr_flip(flip_a), .held(held_a), .q(q_a)
  );

  mwram_port #(
    .W(WIDTH_B), .AB(ABITS_B), .LANE(LANE), .BEN(BEN_B), .RDW_NEW(RDW_NEW)
  ) u_port_b (
    .clk(clk_b), .ce(ce_b), .aclr(aclr_b), .addr(addr_b), .stall(stall_b),
    .we(we_b), .re(re_b), .be(be_b), .din(din_b),
    .rd_own(b_own), .rd_other(b_sees_a),
    .eff_addr(eff_b), .wr_en(wen_b), .wr_flip(flip_b), .held(held_b), .q(q_b)
  );

endmodule

// File: rtl/mwram_tdp_chk.sv
module mwram_tdp_chk #(
  parameter int WA  = 16,
  parameter int WB  = 4,
  parameter int AWA = 9,
  parameter int AWB = 11
) (
  input logic           clk_a,
  input logic           ce_a,
  input logic           aclr_a,
  input logic           stall_a,
  input logic           re_a,
  input logic [AWA-1:0] addr_a,
  input logic [AWA-1:0] held_a,
  input logic [WA-1:0]  q_a,
  input logic           clk_b,
  input logic           ce_b,
  input logic           aclr_b,
  input logic           stall_b,
  input logic           re_b,
  input logic [AWB-1:0] addr_b,
  input logic [AWB-1:0] held_b,
  input logic [WB-1:0]  q_b
);

  AST_CLEAR_Q_A: assert property (@(posedge clk_a)
    aclr_a |-> (q_a == '0 && held_a == '0)); // R8
  AST_CLEAR_Q_B: assert property (@(posedge clk_b)
    aclr_b |-> (q_b == '0 && held_b == '0)); // R8

  AST_NORD_HOLD_A: assert property (@(posedge clk_a) disable iff (aclr_a)
    (ce_a && !re_a) |=> $stable(q_a)); // R3
  AST_NORD_HOLD_B: assert property (@(posedge clk_b) disable iff (aclr_b)
    (ce_b && !re_b) |=> $stable(q_b)); // R3

  AST_CE_FREEZE_A: assert property (@(posedge clk_a) disable iff (aclr_a)
    !ce_a |=> ($stable(q_a) && $stable(held_a))); // R4
  AST_CE_FREEZE_B: assert property (@(posedge clk_b) disable iff (aclr_b)
    !ce_b |=> ($stable(q_b) && $stable(held_b))); // R4

  AST_STALL_KEEP_A: assert property (@(posedge clk_a) disable iff (aclr_a)
    (ce_a && stall_a) |=> $stable(held_a)); // R5
  AST_STALL_KEEP_B: assert property (@(posedge clk_b) disable iff (aclr_b)
    (ce_b && stall_b) |=> $stable(held_b)); // R5

  AST_ADDR_LATCH_A: assert property (@(posedge clk_a) disable iff (aclr_a)
    (ce_a && !stall_a) |=> (held_a == $past(addr_a))); // R5
  AST_ADDR_LATCH_B: assert property (@(posedge clk_b) disable iff (aclr_b)
    (ce_b && !stall_b) |=> (held_b == $past(addr_b))); // R5

endmodule

bind mwram_tdp mwram_tdp_chk #(
  .WA(WIDTH_A), .WB(WIDTH_B), .AWA(ABITS_A), .AWB(ABITS_B)
) u_chk (
  .clk_a(clk_a), .ce_a(ce_a), .aclr_a(aclr_a), .stall_a(stall_a), .re_a(re_a),
  .addr_a(addr_a), .held_a(held_a), .q_a(q_a),
  .clk_b(clk_b), .ce_b(ce_b), .aclr_b(aclr_b), .stall_b(stall_b), .re_b(re_b),
  .addr_b(addr_b), .held_b(held_b), .q_b(q_b)
);

// File: tb/tb_mwram_tdp.sv
module tb_mwram_tdp;

  localparam int WA = 16;
  localparam int WB = 4;

  logic clk_a = 1'b0, clk_b = 1'b0;
  always #10 clk_a = ~clk_a;   // 50 MHz
  always #14 clk_b = ~clk_b;   // unrelated second clock

  logic        ce_a = 0, aclr_a = 1, stall_a = 0, we_a = 0, re_a = 0;
  logic [8:0]  addr_a = '0;
  logic [1:0]  be_a = '0;
  logic [15:0] din_a = '0;
  logic        ce_b = 0, aclr_b = 1, stall_b = 0, we_b = 0, re_b = 0;
  logic [10:0] addr_b = '0;
  logic [0:0]  be_b = '0;
  logic [3:0]  din_b = '0;
  logic [15:0] qa_n, qa_o;
  logic [3:0]  qb_n, qb_o;

  mwram_tdp #(.WIDTH_A(WA), .WIDTH_B(WB), .RDW_NEW(1'b1)) dut (
    .clk_a(clk_a), .ce_a(ce_a), .aclr_a(aclr_a), .addr_a(addr_a), .stall_a(stall_a),
    .we_a(we_a), .re_a(re_a), .be_a(be_a), .din_a(din_a), .q_a(qa_n),
    .clk_b(clk_b), .ce_b(ce_b), .aclr_b(aclr_b), .addr_b(addr_b), .stall_b(stall_b),
    .we_b(we_b), .re_b(re_b), .be_b(be_b), .din_b(din_b), .q_b(qb_n));

  mwram_tdp #(.WIDTH_A(WA), .WIDTH_B(WB), .RDW_NEW(1'b0)) dut_old (
    .clk_a(clk_a), .ce_a(ce_a), .aclr_a(aclr_a), .addr_a(addr_a), .stall_a(stall_a),
    .we_a(we_a), .re_a(re_a), .be_a(be_a), .din_a(din_a), .q_a(qa_o),
    .clk_b(clk_b), .ce_b(ce_b), .aclr_b(aclr_b), .addr_b(addr_b), .stall_b(stall_b),
    .we_b(we_b), .re_b(re_b), .be_b(be_b), .din_b(din_b), .q_b(qb_o));

  typedef struct {
    logic [15:0] exp_new;
    logic [15:0] exp_old;
    string       tag;
  } exp_t;

  exp_t exp_qa[$];
  exp_t exp_qb[$];

  int n_tests = 0, n_fail = 0;
  bit [8191:0] mem_m = '0;
  logic [8:0]  hold_a_m = '0;
  logic [10:0] hold_b_m = '0;
  logic [15:0] qa_new_m = '0, qa_old_m = '0;
  logic [15:0] qb_new_m = '0, qb_old_m = '0;

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver, port A: one enabled or idle edge per call
  task automatic op_a(bit ce, bit st, logic [8:0] ad, bit we, bit re,
                      logic [1:0] be, logic [15:0] din, string tag);
    logic [8:0]  e;
    logic [15:0] old;
    int          base;
    @(negedge clk_a);
    ce_a = ce; stall_a = st; addr_a = ad; we_a = we; re_a = re; be_a = be; din_a = din;
    @(posedge clk_a);
    if (ce) begin
      e = st ? hold_a_m : ad;
      hold_a_m = e;
      base = int'(e) * 16;
      old = mem_m[base +: 16];
      if (we) begin
        for (int k = 0; k < 2; k++)
          if (be[k]) mem_m[base + k*8 +: 8] = din[k*8 +: 8];
      end
      if (re) begin
        qa_new_m = mem_m[base +: 16];
        qa_old_m = old;
      end
    end
    exp_qa.push_back('{qa_new_m, qa_old_m, tag});
  endtask

  task automatic op_b(bit ce, bit st, logic [10:0] ad, bit we, bit re,
                      logic [0:0] be, logic [3:0] din, string tag);
    logic [10:0] e;
    logic [3:0]  old;
    int          base;
    @(negedge clk_b);
    ce_b = ce; stall_b = st; addr_b = ad; we_b = we; re_b = re; be_b = be; din_b = din;
    @(posedge clk_b);
    if (ce) begin
      e = st ? hold_b_m : ad;
      hold_b_m = e;
      base = int'(e) * 4;
      old = mem_m[base +: 4];
      if (we) mem_m[base +: 4] = din;   // narrow port: byte enable has no effect
      if (re) begin
        qb_new_m = {12'h0, mem_m[base +: 4]};
        qb_old_m = {12'h0, old};
      end
    end
    exp_qb.push_back('{qb_new_m, qb_old_m, tag});
  endtask

  // monitors: compare results half a period after each edge
  always @(negedge clk_a) begin
    while (exp_qa.size() > 0) begin
      exp_t it;
      it = exp_qa.pop_front();
      chk({it.tag, " [A new-data]"}, qa_n, it.exp_new);
      chk({it.tag, " [A old-data]"}, qa_o, it.exp_old);
    end
  end

  always @(negedge clk_b) begin
    while (exp_qb.size() > 0) begin
      exp_t it;
      it = exp_qb.pop_front();
      chk({it.tag, " [B new-data]"}, {12'h0, qb_n}, it.exp_new);
      chk({it.tag, " [B old-data]"}, {12'h0, qb_o}, it.exp_old);
    end
  end

  initial begin
    repeat (20000) @(posedge clk_a);
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // R8: reset state while clear is held
    repeat (3) @(posedge clk_a);
    @(negedge clk_a);
    chk("R8 reset q_a", qa_n, 16'h0);
    chk("R8 reset q_a old", qa_o, 16'h0);
    chk("R8 reset q_b", {12'h0, qb_n}, 16'h0);
    chk("R8 reset q_b old", {12'h0, qb_o}, 16'h0);
    #2 aclr_a = 0; aclr_b = 0;

    // R1: write then read back
    op_a(1, 0, 9'd5,  1, 0, 2'b11, 16'h1234, "R1 write A5");
    op_a(1, 0, 9'd5,  0, 1, 2'b11, 16'h0000, "R1 read A5");
    op_a(1, 0, 9'd0,  1, 0, 2'b11, 16'h5A5A, "R1 write A0");
    op_a(1, 0, 9'd0,  0, 1, 2'b11, 16'h0000, "R1 read A0");
    // R2: wide write, narrow reads 40..43 must give F,E,E,B
    op_a(1, 0, 9'd10, 1, 0, 2'b11, 16'hBEEF, "R2 wide write");
    // R6: lane enables
    op_a(1, 0, 9'd30, 1, 0, 2'b11, 16'hFFFF, "R6 fill");
    op_a(1, 0, 9'd30, 1, 0, 2'b01, 16'h0000, "R6 low lane only");
    op_a(1, 0, 9'd30, 0, 1, 2'b11, 16'h0000, "R6 read FF00");
    op_a(1, 0, 9'd30, 1, 0, 2'b10, 16'h1111, "R6 high lane only");
    op_a(1, 0, 9'd30, 0, 1, 2'b11, 16'h0000, "R6 read 1100");
    op_a(0, 0, 9'd0,  0, 0, 2'b00, 16'h0000, "R4 park A");

    op_b(1, 0, 11'd40, 0, 1, 1'b0, 4'h0, "R2 narrow read 40");
    op_b(1, 0, 11'd41, 0, 1, 1'b0, 4'h0, "R2 narrow read 41");
    op_b(1, 0, 11'd42, 0, 1, 1'b0, 4'h0, "R2 narrow read 42");
    op_b(1, 0, 11'd43, 0, 1, 1'b0, 4'h0, "R2 narrow read 43");
    op_b(1, 0, 11'd80, 1, 0, 1'b0, 4'h3, "R2 narrow write 80");
    op_b(1, 0, 11'd81, 1, 0, 1'b0, 4'h5, "R2 narrow write 81");
    op_b(1, 0, 11'd200, 1, 0, 1'b0, 4'h7, "R6 narrow be ignored");
    op_b(1, 0, 11'd200, 0, 1, 1'b0, 4'h0, "R6 narrow readback");
    op_b(1, 0, 11'd300, 1, 1, 1'b0, 4'hC, "R7 B same-address");
    op_b(0, 0, 11'd0, 0, 0, 1'b0, 4'h0, "R4 park B");

    op_a(1, 0, 9'd20, 0, 1, 2'b11, 16'h0000, "R2 wide read of narrow 80/81");
    // R3: no read keeps q, even across a write
    op_a(1, 0, 9'd30, 0, 1, 2'b11, 16'h0000, "R3 prime");
    op_a(1, 0, 9'd31, 1, 0, 2'b11, 16'hAAAA, "R3 write without read");
    op_a(1, 1, 9'd31, 0, 0, 2'b11, 16'h0000, "R3 idle enabled");
    // R4: clock enable low freezes everything
    op_a(1, 0, 9'd5,  0, 1, 2'b11, 16'h0000, "R4 prime");
    op_a(0, 0, 9'd30, 1, 1, 2'b11, 16'h9999, "R4 ce low");
    op_a(1, 1, 9'd77, 0, 1, 2'b11, 16'h0000, "R4 address kept");
    op_a(1, 0, 9'd30, 0, 1, 2'b11, 16'h0000, "R4 memory untouched");
    // R5: stall uses the latched address for writes and reads
    op_a(1, 0, 9'd5,  0, 0, 2'b11, 16'h0000, "R5 latch 5");
    op_a(1, 1, 9'd99, 1, 0, 2'b11, 16'h7777, "R5 stalled write");
    op_a(1, 0, 9'd99, 0, 1, 2'b11, 16'h0000, "R5 addr 99 untouched");
    op_a(1, 0, 9'd5,  0, 1, 2'b11, 16'h0000, "R5 held address written");
    // R7: read-during-write on the same port
    op_a(1, 0, 9'd5,  1, 1, 2'b11, 16'h4444, "R7 full word");
    op_a(1, 0, 9'd5,  1, 1, 2'b10, 16'hABCD, "R7 partial lanes");
    op_a(0, 0, 9'd0,  0, 0, 2'b00, 16'h0000, "R4 park A");

    // R9: both ports busy on disjoint addresses
    fork
      begin
        for (int i = 0; i < 4; i++)
          op_a(1, 0, 9'(300 + i), 1, 0, 2'b11, 16'(16'h1000 + i), "R9 A write");
        for (int i = 0; i < 4; i++)
          op_a(1, 0, 9'(300 + i), 0, 1, 2'b11, 16'h0000, "R9 A read");
        op_a(0, 0, 9'd0, 0, 0, 2'b00, 16'h0000, "R4 park A");
      end
      begin
        for (int i = 0; i < 4; i++)
          op_b(1, 0, 11'(1600 + i), 1, 0, 1'b0, 4'(i + 3), "R9 B write");
        for (int i = 0; i < 4; i++)
          op_b(1, 0, 11'(1600 + i), 0, 1, 1'b0, 4'h0, "R9 B read");
        op_b(0, 0, 11'd0, 0, 0, 1'b0, 4'h0, "R4 park B");
      end
    join
    op_a(1, 0, 9'd400, 0, 1, 2'b11, 16'h0000, "R9 B data seen by A");

    // R8: clear mid-run, q drops at once, latched address returns to 0
    op_a(1, 0, 9'd301, 0, 1, 2'b11, 16'h0000, "R8 prime");
    op_a(0, 0, 9'd0,   0, 0, 2'b00, 16'h0000, "R4 park A");
    @(negedge clk_a);
    #2 aclr_a = 1;
    #1;
    chk("R8 async clear q_a", qa_n, 16'h0);
    chk("R8 async clear q_a old", qa_o, 16'h0);
    qa_new_m = '0; qa_old_m = '0; hold_a_m = '0;
    @(posedge clk_a);
    @(negedge clk_a);
    #2 aclr_a = 0;
    op_a(1, 1, 9'd123, 0, 1, 2'b11, 16'h0000, "R8 held address cleared");
    op_a(0, 0, 9'd0,   0, 0, 2'b00, 16'h0000, "R4 park A");

    repeat (2) @(negedge clk_a);
    repeat (2) @(negedge clk_b);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule